// File: doc/BRIEF.md
# Hardware Page-Table Walker with Directory Cache

This block handles address translation for a first-level TLB when the TLB misses. It takes a 27-bit virtual page number and walks a three-level page table in memory: each level uses one 9-bit slice of the page number, and each table entry is 8 bytes. The walk ends with a leaf translation or a page fault, and the result goes back to the TLB for the refill. No software trap is involved. A leaf at either upper level describes a huge page. The walker then returns a size code, and fills the low bits of the physical page number from the virtual page number.

For each cacheable level, the walker keeps a small fully associative cache of non-leaf directory pointers. The key is the virtual-page-number prefix that leads to that table. On a new miss, the walker starts at the deepest level whose prefix hits, so the upper-level memory reads are skipped. It serves one walk at a time. Memory reads go out on a valid/ready request port, and the data returns after any number of cycles. A flush input empties every directory cache.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and after it is released, `reqReady` is 1, `respValid` is 0 and `memReqValid` is 0.
- R2: Each memory read address is the table base page number shifted left by 12, plus the current 9-bit VPN slice times 8. A walk that starts at the root reads `rootPpn`'s table at VPN bits [26:18].
- R3: Table entries use this layout: V in bit 0, R in bit 1, W in bit 2, X in bit 3, and the next page number in bits [53:10]. An entry is a leaf when R or X is 1. A walk with an empty directory cache that ends in a level-0 leaf makes 3 reads and returns that page number with size code 0 (4 KiB).
- R4: A level-1 leaf returns size code 1, with page-number bits [8:0] taken from VPN bits [8:0]. A level-2 leaf returns size code 2, with page-number bits [17:0] taken from VPN bits [17:0].
- R5: An entry with V=0 ends the walk with `respFault`=1, and both page number and size read 0.
- R6: An entry with W=1 and R=0 ends the walk with a fault.
- R7: A valid non-leaf entry found at level 0 ends the walk with a fault.
- R8: When a finished walk has cached a pointer for the same VPN bits [26:9], a new walk makes 1 read. When only VPN bits [26:18] match a cached pointer, it makes 2 reads.
- R9: A one-cycle pulse on `flush` empties all directory caches, so the next walk starts at the root again.
- R10: Only one walk is in flight at a time. `reqReady` stays 0 from the accept until the response handshake. The response holds steady while `respReady` is 0.
- R11: A memory request keeps `memReqValid` high and its address unchanged until `memReqReady`, and any response latency is accepted.
- R12: Each directory level holds 4 entries and replaces them in round-robin order, so a fifth distinct prefix evicts the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties all directory caches |
| rootPpn | input | 44 | Page number of the root table |
| reqValid | input | 1 | Miss request valid |
| reqReady | output | 1 | Walker idle and able to accept |
| reqVpn | input | 27 | Virtual page number to translate |
| respValid | output | 1 | Result valid |
| respReady | input | 1 | TLB accepts result |
| respPpn | output | 44 | Translated physical page number |
| respSize | output | 2 | 0: 4 KiB, 1: 2 MiB, 2: 1 GiB |
| respFault | output | 1 | Walk ended in a page fault |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 56 | Byte address of the table entry |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 64 | Table entry read back |

## Verification
Assertions check several things on every cycle. The memory request and the TLB response must stay held while stalled, and no request is accepted while a result is pending. No directory cache ever holds two matching entries for one prefix, and a flush leaves every cache empty. The walker never tries to descend below level 0. Other behaviour can only be shown by the bench's scenarios: how many reads each walk makes depends on what earlier walks cached, round-robin eviction shows up only after five distinct prefixes, and huge-page bit merging and fault classes need specific page-table contents.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int SLICE_W     = 9;
  localparam int LEVELS      = 3;
  localparam int VPN_W       = SLICE_W * LEVELS;
  localparam int PTE_W       = 64;
  localparam int ENTRY_SHIFT = 3;
  localparam int PAGE_SHIFT  = SLICE_W + ENTRY_SHIFT;
  localparam int PTE_PPN_LSB = 10;
  localparam int LVL_W       = $clog2(LEVELS);

  typedef struct packed {
    logic loadVpn;
    logic startWalk;
    logic latchPte;
    logic descend;
  } ptwStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_MEMREQ, ST_MEMWAIT, ST_CHECK, ST_RESP
  } ptwState_t;
endpackage

// File: rtl/ptw_dir_cache.sv
module ptw_dir_cache #(
  parameter int KEY_W   = 9,
  parameter int DATA_W  = 44,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              fillEn,
  input  logic [KEY_W-1:0]  fillKey,
  input  logic [DATA_W-1:0] fillData,
  input  logic [KEY_W-1:0]  lookKey,
  output logic              hit,
  output logic [DATA_W-1:0] hitData
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] hitVec;
  logic [KEY_W-1:0]   keyQ  [ENTRIES];
  logic [DATA_W-1:0]  dataQ [ENTRIES];
  logic [IDX_W-1:0]   ptrQ;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hitVec[i] = validQ[i] && (keyQ[i] == lookKey);
  end

  assign hit = |hitVec;

  always_comb begin
    hitData = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hitVec[i]) hitData |= dataQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      ptrQ   <= '0;
    end else if (flush) begin
      validQ <= '0;
      ptrQ   <= '0;
    end else if (fillEn) begin
      validQ[ptrQ] <= 1'b1;
      ptrQ <= (ptrQ == LAST_IDX) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn && !flush) begin
      keyQ[ptrQ]  <= fillKey;
      dataQ[ptrQ] <= fillData;
    end
  end

  // R12
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validQ == '0));
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath import ptw_pkg::*; #(
  parameter int PPN_W      = 44,
  parameter int DC_ENTRIES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ptwStrobes_t                 strb,
  input  logic                        flush,
  input  logic [VPN_W-1:0]            reqVpn,
  input  logic [PPN_W-1:0]            rootPpn,
  input  logic [PTE_W-1:0]            memRespData,
  output logic [PPN_W+PAGE_SHIFT-1:0] memReqAddr,
  output logic                        pteFault,
  output logic                        pteLeaf,
  output logic [PPN_W-1:0]            respPpn,
  output logic [1:0]                  respSize
);
  logic [VPN_W-1:0] vpnQ;
  logic [LVL_W-1:0] levelQ;
  logic [PPN_W-1:0] baseQ;
  logic [PTE_W-1:0] pteQ;

  logic             hitLvl  [LEVELS-1:1];
  logic [PPN_W-1:0] hitBase [LEVELS-1:1];
  logic [LVL_W-1:0] startLvl;
  logic [PPN_W-1:0] startBase;

  // cache g holds pointers reached through the top g slices
  for (genvar g = 1; g < LEVELS; g++) begin : g_dc
    localparam int KW = SLICE_W * g;
    ptw_dir_cache #(.KEY_W(KW), .DATA_W(PPN_W), .ENTRIES(DC_ENTRIES)) u_dc (
      .clk      (clk),
      .rstN     (rstN),
      .flush    (flush),
      .fillEn   (strb.descend && (levelQ == LVL_W'(LEVELS - g))),
      .fillKey  (vpnQ[VPN_W-1 -: KW]),
      .fillData (pteQ[PTE_PPN_LSB +: PPN_W]),
      .lookKey  (vpnQ[VPN_W-1 -: KW]),
      .hit      (hitLvl[g]),
      .hitData  (hitBase[g])
    );
  end

  always_comb begin
    startLvl  = LVL_W'(LEVELS - 1);
    startBase = rootPpn;
    for (int g = 1; g < LEVELS; g++) begin
      if (hitLvl[g]) begin
        startLvl  = LVL_W'(LEVELS - 1 - g);
        startBase = hitBase[g];
      end
    end
  end

  logic             pteV, pteR, pteW, pteX;
  logic [PPN_W-1:0] ptePpn;
  logic [SLICE_W-1:0] curSlice;
  logic [PPN_W-1:0] lowMask;
  logic             unusedPteBits;

  assign pteV   = pteQ[0];
  assign pteR   = pteQ[1];
  assign pteW   = pteQ[2];
  assign pteX   = pteQ[3];
  assign ptePpn = pteQ[PTE_PPN_LSB +: PPN_W];
  assign unusedPteBits = ^{pteQ[PTE_W-1:PTE_PPN_LSB+PPN_W], pteQ[PTE_PPN_LSB-1:4]};

  assign pteLeaf  = pteR | pteX;
  assign pteFault = !pteV || (pteW && !pteR) || (!pteLeaf && levelQ == '0);

  assign curSlice   = vpnQ[int'(levelQ) * SLICE_W +: SLICE_W];
  assign memReqAddr = {baseQ, curSlice, ENTRY_SHIFT'(0)};

  assign lowMask  = (PPN_W'(1) << (int'(levelQ) * SLICE_W)) - PPN_W'(1);
  assign respPpn  = pteFault ? '0 : ((ptePpn & ~lowMask) | (PPN_W'(vpnQ) & lowMask));
  assign respSize = pteFault ? 2'd0 : 2'(levelQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ   <= '0;
      levelQ <= '0;
      baseQ  <= '0;
      pteQ   <= '0;
    end else begin
      if (strb.loadVpn) vpnQ <= reqVpn;
      if (strb.startWalk) begin
        levelQ <= startLvl;
        baseQ  <= startBase;
      end else if (strb.descend) begin
        levelQ <= levelQ - 1'b1;
        baseQ  <= ptePpn;
      end
      if (strb.latchPte) pteQ <= memRespData;
    end
  end

  // R7
  descend_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.descend |-> (levelQ != '0));
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl import ptw_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        respReady,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  logic        pteFault,
  input  logic        pteLeaf,
  output logic        reqReady,
  output logic        respValid,
  output logic        memReqValid,
  output ptwStrobes_t strb
);
  ptwState_t stateQ, stateD;

  always_comb begin
    stateD      = stateQ;
    strb        = '0;
    reqReady    = 1'b0;
    respValid   = 1'b0;
    memReqValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.loadVpn = 1'b1;
          stateD = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        strb.startWalk = 1'b1;
        stateD = ST_MEMREQ;
      end
      ST_MEMREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_MEMWAIT;
      end
      ST_MEMWAIT: begin
        if (memRespValid) begin
          strb.latchPte = 1'b1;
          stateD = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (pteFault || pteLeaf) stateD = ST_RESP;
        else begin
          strb.descend = 1'b1;
          stateD = ST_MEMREQ;
        end
      end
      ST_RESP: begin
        respValid = 1'b1;
        if (respReady) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R10
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respReady |=> respValid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker import ptw_pkg::*; #(
  parameter int PPN_W      = 44,
  parameter int DC_ENTRIES = 4,
  localparam int PA_W      = PPN_W + PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [PPN_W-1:0] rootPpn,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VPN_W-1:0] reqVpn,
  output logic             respValid,
  input  logic             respReady,
  output logic [PPN_W-1:0] respPpn,
  output logic [1:0]       respSize,
  output logic             respFault,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRespValid,
  input  logic [PTE_W-1:0] memRespData
);
  ptwStrobes_t strb;
  logic        pteFault, pteLeaf;

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .respReady    (respReady),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .pteFault     (pteFault),
    .pteLeaf      (pteLeaf),
    .reqReady     (reqReady),
    .respValid    (respValid),
    .memReqValid  (memReqValid),
    .strb         (strb)
  );

  ptw_datapath #(.PPN_W(PPN_W), .DC_ENTRIES(DC_ENTRIES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .flush       (flush),
    .reqVpn      (reqVpn),
    .rootPpn     (rootPpn),
    .memRespData (memRespData),
    .memReqAddr  (memReqAddr),
    .pteFault    (pteFault),
    .pteLeaf     (pteLeaf),
    .respPpn     (respPpn),
    .respSize    (respSize)
  );

  assign respFault = pteFault;

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R10
  resp_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respReady |=> $stable(respPpn) && $stable(respFault) && $stable(respSize));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic [43:0] rootPpn = 44'h100;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [26:0] reqVpn = '0;
  logic        respValid;
  logic        respReady = 1'b0;
  logic [43:0] respPpn;
  logic [1:0]  respSize;
  logic        respFault;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [55:0] memReqAddr;
  logic        memRespValid = 1'b0;
  logic [63:0] memRespData = '0;

  pt_walker dut (.*);

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  int totalCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  endtask

  // page-table contents, computed from the byte address
  function automatic logic [63:0] mkPte(input logic [43:0] p, input logic [9:0] fl);
    return (64'(p) << 10) | 64'(fl);
  endfunction

  function automatic logic [63:0] pteAt(input logic [55:0] a);
    logic [43:0] p;
    logic [8:0]  idx;
    p   = a[55:12];
    idx = a[11:3];
    if (p == 44'h100) begin
      if (idx == 9'd1) return mkPte(44'h200, 10'h001);
      if (idx == 9'd2) return mkPte(44'h40000, 10'h00B);
      if (idx == 9'd3) return 64'h5;
    end else if (p == 44'h200) begin
      if (idx <= 9'd5) return mkPte(44'h300 + 44'(idx), 10'h001);
      if (idx == 9'd7) return mkPte(44'h1200, 10'h007);
    end else if (p >= 44'h300 && p <= 44'h305) begin
      if (idx == 9'd5) return mkPte(44'h5000 + (p - 44'h300), 10'h00F);
      if (idx == 9'd6) return mkPte(44'h400, 10'h001);
    end
    return 64'h0;
  endfunction

  // memory responder, driven at the falling edge
  int memStall = 0;
  int memLat   = 1;
  int readCnt  = 0;
  logic [55:0] firstAddr = '0, lastRead = '0;
  logic [55:0] seenAddr = '0, capAddr = '0;
  bit seenValid = 0, busy = 0, heldBad = 0;
  int stallCnt = 0, latCnt = 0;

  always @(negedge clk) begin
    memRespValid = 1'b0;
    if (!rstN) begin
      memReqReady = 1'b0; busy = 0; seenValid = 0; stallCnt = 0;
    end else if (busy) begin
      if (latCnt == 0) begin
        memRespValid = 1'b1;
        memRespData  = pteAt(capAddr);
        busy = 0;
      end else latCnt--;
    end else if (memReqReady) begin
      memReqReady = 1'b0;
      capAddr = seenAddr;
      readCnt++;
      if (readCnt == 1) firstAddr = capAddr;
      lastRead = capAddr;
      seenValid = 0;
      busy = 1;
      latCnt = memLat - 1;
    end else if (memReqValid) begin
      if (seenValid && memReqAddr != seenAddr) heldBad = 1;
      seenAddr = memReqAddr;
      seenValid = 1;
      if (stallCnt >= memStall) begin memReqReady = 1'b1; stallCnt = 0; end
      else stallCnt++;
    end else if (seenValid) begin
      heldBad = 1;
    end
  end

  logic [43:0] gotPpn;
  logic [1:0]  gotSize;
  logic        gotFault;

  task automatic doWalk(input logic [26:0] v);
    @(negedge clk);
    readCnt = 0;
    reqVpn = v; reqValid = 1'b1; respReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid) @(negedge clk);
    gotPpn = respPpn; gotSize = respSize; gotFault = respFault;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [26:0] vpn;
    logic [43:0] ppn;
    logic [1:0]  size;
    logic        fault;
    logic [1:0]  reads;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{{9'd1, 9'd0, 9'd5},      44'h5000,  2'd0, 1'b0, 2'd3, 8'd3},   // R3 cold walk
    '{{9'd1, 9'd0, 9'd9},      44'h0,     2'd0, 1'b1, 2'd1, 8'd5},   // R5 V=0 at level 0, R8 shortcut
    '{{9'd1, 9'd0, 9'd5},      44'h5000,  2'd0, 1'b0, 2'd1, 8'd8},   // R8 deepest hit
    '{{9'd1, 9'd1, 9'd5},      44'h5001,  2'd0, 1'b0, 2'd2, 8'd8},   // R8 upper hit only
    '{{9'd1, 9'd7, 9'h1AB},    44'h13AB,  2'd1, 1'b0, 2'd1, 8'd4},   // R4 2 MiB
    '{{9'd2, 9'h55, 9'h0AA},   44'h4AAAA, 2'd2, 1'b0, 2'd1, 8'd4},   // R4 1 GiB
    '{{9'd3, 9'd0, 9'd0},      44'h0,     2'd0, 1'b1, 2'd1, 8'd6},   // R6 W without R
    '{{9'd4, 9'd0, 9'd0},      44'h0,     2'd0, 1'b1, 2'd1, 8'd5},   // R5 V=0 at root
    '{{9'd1, 9'd0, 9'd6},      44'h0,     2'd0, 1'b1, 2'd1, 8'd7},   // R7 pointer at level 0
    '{{9'd1, 9'd2, 9'd5},      44'h5002,  2'd0, 1'b0, 2'd2, 8'd12},  // R12 fill third slot
    '{{9'd1, 9'd3, 9'd5},      44'h5003,  2'd0, 1'b0, 2'd2, 8'd12},  // R12 fill fourth slot
    '{{9'd1, 9'd4, 9'd5},      44'h5004,  2'd0, 1'b0, 2'd2, 8'd12},  // R12 evicts oldest
    '{{9'd1, 9'd1, 9'd5},      44'h5001,  2'd0, 1'b0, 2'd1, 8'd12},  // R12 second slot kept
    '{{9'd1, 9'd0, 9'd5},      44'h5000,  2'd0, 1'b0, 2'd2, 8'd12},  // R12 oldest gone
    '{{9'd1, 9'd1, 9'd5},      44'h5001,  2'd0, 1'b0, 2'd2, 8'd12}   // R12 next victim
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    chk(reqReady && !respValid && !memReqValid, "R1 in reset",
        {reqReady, respValid, memReqValid}, 3'b100);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R1 after release
    chk(reqReady && !respValid && !memReqValid, "R1 after reset",
        {reqReady, respValid, memReqValid}, 3'b100);

    for (int i = 0; i < NV; i++) begin
      memStall = i % 3;
      memLat   = 1 + (i % 4);
      doWalk(VECS[i].vpn);
      chk(gotPpn == VECS[i].ppn && gotSize == VECS[i].size && gotFault == VECS[i].fault,
          $sformatf("R%0d result vec %0d", VECS[i].req, i),
          {gotFault, gotSize, gotPpn}, {VECS[i].fault, VECS[i].size, VECS[i].ppn});
      chk(readCnt == int'(VECS[i].reads), $sformatf("R%0d reads vec %0d", VECS[i].req, i),
          64'(readCnt), 64'(VECS[i].reads));
    end

    // R9 flush returns walks to the root; R2 address formation
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    memStall = 2; memLat = 3;
    doWalk({9'd1, 9'd0, 9'd5});
    chk(readCnt == 3, "R9 reads after flush", 64'(readCnt), 64'd3);
    chk(firstAddr == 56'h100008, "R2 root entry address", 64'(firstAddr), 64'h100008);
    chk(lastRead == 56'h300028, "R2 leaf entry address", 64'(lastRead), 64'h300028);

    // R10 response held while TLB stalls, no new accept
    @(negedge clk);
    reqVpn = {9'd1, 9'd3, 9'd5}; reqValid = 1'b1; respReady = 1'b0;
    @(negedge clk); reqValid = 1'b0;
    while (!respValid) @(negedge clk);
    begin
      bit stayed = 1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (!respValid || reqReady || respPpn != 44'h5003) stayed = 0;
      end
      chk(stayed, "R10 hold while stalled", {respValid, reqReady, respPpn}, {2'b10, 44'h5003});
    end
    respReady = 1'b1;
    @(negedge clk);
    chk(!respValid && reqReady, "R10 release after handshake", {respValid, reqReady}, 2'b01);

    // R11 request held through memory stalls
    chk(!heldBad, "R11 request held until ready", 64'(heldBad), 64'd0);

    done = 1;
    finishRun();
  end
endmodule